// File: doc/BRIEF.md
# Two-Way Doorbell Mailbox Register Bank

This block sits between a host register port and a service-engine register port. The host places a command into a small set of 64-bit words, then rings a doorbell toward the engine. The engine reads the command, answers through its own set of 64-bit response words, and rings a second doorbell back toward the host. Each doorbell is a 64-bit register with a level interrupt. The interrupt stays high while any bit of that doorbell is set. It drops as soon as the reader has cleared the bits.

Both ports use the same synchronous word-addressed register protocol and share one address map. Every doorbell can be reached through three aliases: a plain write, a bitwise-OR set, and a bitwise-AND clear. A writer can therefore raise one event bit, and a reader can retire one, without a read-modify-write sequence. The engine-to-host doorbell carries several typed event bits side by side, and their low bits are also brought out directly.

Top module: `mbox_regbank`

## Requirements
- R1: After reset, all data words and both doorbells read as zero, `h_irq`, `e_irq`, `h_evt`, `h_rdata` and `e_rdata` are zero.
- R2: Command words live at addresses 0 to 3 and are written only by the host. Either side can read them. A read issued with `req=1, we=0` returns its data on `*_rdata` one cycle later. `*_rdata` holds its value while no read is issued.
- R3: Response words live at addresses 4 to 7 and are written only by the engine. Either side can read them.
- R4: A write from the engine to addresses 0 to 3, or from the host to addresses 4 to 7, is ignored.
- R5: The host-to-engine doorbell is at address 8 (plain), 9 (OR-set) and 10 (AND-clear). The engine-to-host doorbell is at 11, 12 and 13. An AND-clear write ANDs the register with the written mask. Either side may use any alias. A read of any of the three aliases returns the doorbell.
- R6: `e_irq` is high exactly while the host-to-engine doorbell is nonzero, and `h_irq` exactly while the engine-to-host doorbell is nonzero. Each level follows the clock edge that updates its doorbell.
- R7: When accesses hit one doorbell in the same cycle, the result is (base AND all clear masks) OR all set masks, so a set beats a clear on the same bit. The base is the host's plain-write value if there is one, otherwise the engine's plain-write value, otherwise the current value.
- R8: Bits of the engine-to-host doorbell carry these events: bit 0 message read, bit 1 response waiting, bit 2 passthrough request, bit 3 timer expiry, bit 4 engine back from reset. `h_evt[4:0]` shows those five bits. Bit 0 of the host-to-engine doorbell means message waiting.
- R9: Reads of addresses 14 and 15 return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host access strobe |
| h_we | input | 1 | Host write enable |
| h_addr | input | 4 | Host word address |
| h_wdata | input | 64 | Host write data |
| h_rdata | output | 64 | Host read data, one cycle after the read |
| h_irq | output | 1 | Level interrupt to host, engine-to-host doorbell nonzero |
| h_evt | output | 5 | Event bits of the engine-to-host doorbell |
| e_req | input | 1 | Engine access strobe |
| e_we | input | 1 | Engine write enable |
| e_addr | input | 4 | Engine word address |
| e_wdata | input | 64 | Engine write data |
| e_rdata | output | 64 | Engine read data, one cycle after the read |
| e_irq | output | 1 | Level interrupt to engine, host-to-engine doorbell nonzero |

## Verification
The two functions that can meet in one cycle are an event being raised on a doorbell by one side and bits being retired from the same doorbell by the other side. The bench drives both ports in the same cycle on one doorbell in three ways: an engine OR-set against a host AND-clear, two plain writes, and a plain write against an OR-set. It then judges the stored value through a read and through `h_evt` and the interrupt level against the combining rule of R7. The key outcome is that a bit being set is never lost to a clear arriving in the same cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Event positions in the engine-to-host doorbell:
  // 0 message read, 1 response waiting, 2 passthrough, 3 timer expiry, 4 back from reset
  localparam int EVT_W = 5;
  // Doorbell index: 0 host-to-engine, 1 engine-to-host
  localparam int BELL_DN = 0;
  localparam int BELL_UP = 1;
  localparam int N_BELL  = 2;
  // Address offset of each alias inside a doorbell's three-word window
  typedef enum logic [1:0] {
    AL_PLAIN = 2'd0,
    AL_SET   = 2'd1,
    AL_CLR   = 2'd2
  } alias_e;
  localparam int N_ALIAS = 3;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int NCMD    = 4,
  parameter bit OWN_RSP = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NCMD-1:0]      data_we,
  output logic [N_BELL-1:0]    bell_wr,
  output logic [N_BELL-1:0]    bell_or,
  output logic [N_BELL-1:0]    bell_and
);
  localparam int CMD_BASE  = 0;
  localparam int RSP_BASE  = NCMD;
  localparam int BELL_BASE = 2 * NCMD;
  localparam int OWN_BASE  = OWN_RSP ? RSP_BASE : CMD_BASE;

  logic wr;
  assign wr = req & we;

  for (genvar i = 0; i < NCMD; i++) begin : g_data
    assign data_we[i] = wr && (addr == ADDR_W'(OWN_BASE + i));
  end

  for (genvar b = 0; b < N_BELL; b++) begin : g_bell
    localparam int WIN = BELL_BASE + N_ALIAS * b;
    assign bell_wr[b]  = wr && (addr == ADDR_W'(WIN + int'(AL_PLAIN)));
    assign bell_or[b]  = wr && (addr == ADDR_W'(WIN + int'(AL_SET)));
    assign bell_and[b] = wr && (addr == ADDR_W'(WIN + int'(AL_CLR)));
  end

  // R9: a read never produces a write strobe
  p_no_strobe_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |-> ({data_we, bell_wr, bell_or, bell_and} == '0));
  // R5: at most one target per access
  p_single_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_we, bell_wr, bell_or, bell_and}));
endmodule

// File: rtl/mbox_dataregs.sv
module mbox_dataregs #(
  parameter int DATA_W = 64,
  parameter int NCMD   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NCMD-1:0]              we,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NCMD-1:0][DATA_W-1:0]  q
);
  for (genvar i = 0; i < NCMD; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)     q[i] <= '0;
      else if (we[i]) q[i] <= wdata;
    end

    // R4: a word not addressed by its owner keeps its value
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !we[i] |=> $stable(q[i]));
    // R2: an owner write lands in the next cycle
    p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we[i] |=> (q[i] == $past(wdata)));
  end
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_wr,
  input  logic              h_or,
  input  logic              h_and,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic              e_wr,
  input  logic              e_or,
  input  logic              e_and,
  input  logic [DATA_W-1:0] e_wdata,
  output logic [DATA_W-1:0] q,
  output logic              irq
);
  // Combining rule: base from plain writes (host first), then clears, then sets
  function automatic logic [DATA_W-1:0] bell_next(
    input logic [DATA_W-1:0] cur,
    input logic              hw, input logic [DATA_W-1:0] hd,
    input logic              ew, input logic [DATA_W-1:0] ed,
    input logic [DATA_W-1:0] setm,
    input logic [DATA_W-1:0] clrm);
    logic [DATA_W-1:0] base;
    base = hw ? hd : (ew ? ed : cur);
    return (base & clrm) | setm;
  endfunction

  logic [DATA_W-1:0] set_mask, clr_mask;
  logic              any_op, clr_like;

  assign set_mask = (h_or ? h_wdata : '0) | (e_or ? e_wdata : '0);
  assign clr_mask = (h_and ? h_wdata : '1) & (e_and ? e_wdata : '1);
  assign any_op   = h_wr | h_or | h_and | e_wr | e_or | e_and;
  assign clr_like = h_wr | h_and | e_wr | e_and;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= bell_next(q, h_wr, h_wdata, e_wr, e_wdata, set_mask, clr_mask);
  end

  assign irq = |q;

  // R7: bits being set survive any clear in the same cycle
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (h_or || e_or) |=> ((q & $past(set_mask)) == $past(set_mask)));
  // R5: a lone host AND-clear masks the old value
  p_and_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (h_and && !h_or && !h_wr && !e_wr && !e_or && !e_and)
      |=> (q == ($past(q) & $past(h_wdata))));
  // R5: no access, no change
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !any_op |=> $stable(q));
  // R6: the interrupt only falls after a clearing or plain write
  p_irq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(clr_like));
endmodule

// File: rtl/mbox_regbank.sv
module mbox_regbank
  import mbox_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NCMD   = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  output logic              h_irq,
  output logic [EVT_W-1:0]  h_evt,
  input  logic              e_req,
  input  logic              e_we,
  input  logic [ADDR_W-1:0] e_addr,
  input  logic [DATA_W-1:0] e_wdata,
  output logic [DATA_W-1:0] e_rdata,
  output logic              e_irq
);
  localparam int CMD_BASE  = 0;
  localparam int RSP_BASE  = NCMD;
  localparam int BELL_BASE = 2 * NCMD;

  logic [NCMD-1:0]             h_data_we, e_data_we;
  logic [N_BELL-1:0]           h_bwr, h_bor, h_band;
  logic [N_BELL-1:0]           e_bwr, e_bor, e_band;
  logic [NCMD-1:0][DATA_W-1:0] cmd_q, rsp_q;
  logic [N_BELL-1:0][DATA_W-1:0] bell_q;
  logic [N_BELL-1:0]           bell_irq;

  mbox_decode #(.ADDR_W(ADDR_W), .NCMD(NCMD), .OWN_RSP(1'b0)) u_hdec (
    .clk(clk), .rst_n(rst_n), .req(h_req), .we(h_we), .addr(h_addr),
    .data_we(h_data_we), .bell_wr(h_bwr), .bell_or(h_bor), .bell_and(h_band));

  mbox_decode #(.ADDR_W(ADDR_W), .NCMD(NCMD), .OWN_RSP(1'b1)) u_edec (
    .clk(clk), .rst_n(rst_n), .req(e_req), .we(e_we), .addr(e_addr),
    .data_we(e_data_we), .bell_wr(e_bwr), .bell_or(e_bor), .bell_and(e_band));

  mbox_dataregs #(.DATA_W(DATA_W), .NCMD(NCMD)) u_cmd (
    .clk(clk), .rst_n(rst_n), .we(h_data_we), .wdata(h_wdata), .q(cmd_q));

  mbox_dataregs #(.DATA_W(DATA_W), .NCMD(NCMD)) u_rsp (
    .clk(clk), .rst_n(rst_n), .we(e_data_we), .wdata(e_wdata), .q(rsp_q));

  for (genvar b = 0; b < N_BELL; b++) begin : g_bell
    mbox_doorbell #(.DATA_W(DATA_W)) u_bell (
      .clk(clk), .rst_n(rst_n),
      .h_wr(h_bwr[b]), .h_or(h_bor[b]), .h_and(h_band[b]), .h_wdata(h_wdata),
      .e_wr(e_bwr[b]), .e_or(e_bor[b]), .e_and(e_band[b]), .e_wdata(e_wdata),
      .q(bell_q[b]), .irq(bell_irq[b]));
  end

  function automatic logic [DATA_W-1:0] read_word(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < NCMD; i++) begin
      if (a == ADDR_W'(CMD_BASE + i)) r = cmd_q[i];
      if (a == ADDR_W'(RSP_BASE + i)) r = rsp_q[i];
    end
    for (int b = 0; b < N_BELL; b++)
      for (int k = 0; k < N_ALIAS; k++)
        if (a == ADDR_W'(BELL_BASE + N_ALIAS * b + k)) r = bell_q[b];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_rdata <= '0;
      e_rdata <= '0;
    end else begin
      if (h_req && !h_we) h_rdata <= read_word(h_addr);
      if (e_req && !e_we) e_rdata <= read_word(e_addr);
    end
  end

  assign e_irq = bell_irq[BELL_DN];
  assign h_irq = bell_irq[BELL_UP];
  assign h_evt = bell_q[BELL_UP][EVT_W-1:0];

  // R2: read data holds while a side issues no read
  p_hrdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_req && !h_we) |=> $stable(h_rdata));
  p_erdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(e_req && !e_we) |=> $stable(e_rdata));
  // R8: an event bit shown to the host implies the host interrupt
  p_evt_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (h_evt != '0) |-> h_irq);
endmodule

// File: tb/mbox_regbank_tb.sv
module mbox_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_req = 1'b0, h_we = 1'b0, e_req = 1'b0, e_we = 1'b0;
  logic [3:0]  h_addr = '0, e_addr = '0;
  logic [63:0] h_wdata = '0, e_wdata = '0;
  logic [63:0] h_rdata, e_rdata;
  logic        h_irq, e_irq;
  logic [4:0]  h_evt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] hq[$], eq[$];
  string       htq[$], etq[$];

  always #10 clk = ~clk;

  mbox_regbank u_dut (
    .clk(clk), .rst_n(rst_n),
    .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_irq(h_irq), .h_evt(h_evt),
    .e_req(e_req), .e_we(e_we), .e_addr(e_addr), .e_wdata(e_wdata),
    .e_rdata(e_rdata), .e_irq(e_irq));

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus on both ports, returns at the next falling edge
  task automatic cyc(input logic hr, input logic hw, input logic [3:0] ha, input logic [63:0] hd,
                     input logic er, input logic ew, input logic [3:0] ea, input logic [63:0] ed);
    h_req = hr; h_we = hw; h_addr = ha; h_wdata = hd;
    e_req = er; e_we = ew; e_addr = ea; e_wdata = ed;
    @(negedge clk);
    h_req = 1'b0; h_we = 1'b0; e_req = 1'b0; e_we = 1'b0;
  endtask

  task automatic hwr(input logic [3:0] a, input logic [63:0] d);
    cyc(1, 1, a, d, 0, 0, 0, 0);
  endtask
  task automatic ewr(input logic [3:0] a, input logic [63:0] d);
    cyc(0, 0, 0, 0, 1, 1, a, d);
  endtask
  task automatic hrd(input logic [3:0] a, input logic [63:0] exp, input string tag);
    hq.push_back(exp); htq.push_back(tag);
    cyc(1, 0, a, 0, 0, 0, 0, 0);
  endtask
  task automatic erd(input logic [3:0] a, input logic [63:0] exp, input string tag);
    eq.push_back(exp); etq.push_back(tag);
    cyc(0, 0, 0, 0, 1, 0, a, 0);
  endtask

  // scoreboard monitor: compares read data after the edge that registers it
  always @(posedge clk) begin
    automatic bit hr = h_req && !h_we && rst_n;
    automatic bit er = e_req && !e_we && rst_n;
    if (hr || er) begin
      #2;
      if (hr) begin
        if (hq.size() == 0) chk(h_rdata, 64'hx, "R2 unexpected host read");
        else chk(h_rdata, hq.pop_front(), htq.pop_front());
      end
      if (er) begin
        if (eq.size() == 0) chk(e_rdata, 64'hx, "R2 unexpected engine read");
        else chk(e_rdata, eq.pop_front(), etq.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({63'b0, h_irq}, 0, "R1 h_irq");
    chk({63'b0, e_irq}, 0, "R1 e_irq");
    chk({59'b0, h_evt}, 0, "R1 h_evt");
    chk(h_rdata, 0, "R1 h_rdata");
    chk(e_rdata, 0, "R1 e_rdata");
    rst_n = 1'b1;
    @(negedge clk);
    hrd(4'd8, 0, "R1 down bell zero");
    erd(4'd2, 0, "R1 cmd2 zero");
    hrd(4'd5, 0, "R1 rsp1 zero");

    // R2 command words
    for (int i = 0; i < 4; i++) hwr(4'(i), 64'hC0DE_0000_0000_0000 + 64'(i));
    for (int i = 0; i < 4; i++) erd(4'(i), 64'hC0DE_0000_0000_0000 + 64'(i), "R2 engine reads cmd");
    hrd(4'd2, 64'hC0DE_0000_0000_0002, "R2 host reads cmd2");
    @(negedge clk);
    chk(h_rdata, 64'hC0DE_0000_0000_0002, "R2 rdata holds");

    // R3 response words
    for (int i = 0; i < 4; i++) ewr(4'(4 + i), 64'hFACE_0000_0000_0010 + 64'(i));
    for (int i = 0; i < 4; i++) hrd(4'(4 + i), 64'hFACE_0000_0000_0010 + 64'(i), "R3 host reads rsp");
    erd(4'd7, 64'hFACE_0000_0000_0013, "R3 engine reads rsp3");

    // R4 wrong-side writes ignored
    ewr(4'd1, 64'hDEAD_BEEF);
    hwr(4'd5, 64'hBAD0_BAD0);
    hrd(4'd1, 64'hC0DE_0000_0000_0001, "R4 cmd1 unchanged");
    erd(4'd5, 64'hFACE_0000_0000_0011, "R4 rsp1 unchanged");

    // R9 unmapped addresses
    hwr(4'd14, 64'hFFFF);
    ewr(4'd15, 64'hFFFF);
    hrd(4'd14, 0, "R9 read 14");
    erd(4'd15, 0, "R9 read 15");
    chk({62'b0, h_irq, e_irq}, 0, "R9 no doorbell touched");

    // R5 / R6 host-to-engine doorbell, bit0 message waiting (R8)
    hwr(4'd9, 64'h1);
    chk({63'b0, e_irq}, 1, "R6 e_irq rises");
    erd(4'd8, 64'h1, "R8 message waiting bit0");
    erd(4'd10, 64'h1, "R5 alias read");
    ewr(4'd10, ~64'h1);
    chk({63'b0, e_irq}, 0, "R6 e_irq falls after clear");
    hwr(4'd8, 64'h30);
    chk({63'b0, e_irq}, 1, "R6 e_irq after plain write");
    hwr(4'd10, 64'h10);
    erd(4'd8, 64'h10, "R5 AND mask");
    ewr(4'd10, 64'h0);
    chk({63'b0, e_irq}, 0, "R6 e_irq low after full clear");

    // R8 event bits on the engine-to-host doorbell
    ewr(4'd12, 64'h3);
    chk({59'b0, h_evt}, 64'h03, "R8 ack and response");
    chk({63'b0, h_irq}, 1, "R6 h_irq rises");
    hwr(4'd13, ~64'h1);
    chk({59'b0, h_evt}, 64'h02, "R8 ack retired");
    ewr(4'd12, 64'h1C);
    chk({59'b0, h_evt}, 64'h1E, "R8 passthrough timer reset");
    hwr(4'd11, 64'h0);
    chk({63'b0, h_irq}, 0, "R6 h_irq falls");

    // R7 same-cycle conflicts
    cyc(1, 1, 4'd13, 64'h0, 1, 1, 4'd12, 64'h2);
    chk({59'b0, h_evt}, 64'h02, "R7 set beats clear");
    chk({63'b0, h_irq}, 1, "R7 irq stays");
    cyc(1, 1, 4'd13, ~64'h2, 1, 1, 4'd12, 64'h4);
    hrd(4'd11, 64'h4, "R7 clear one set other");
    cyc(1, 1, 4'd8, 64'hA, 1, 1, 4'd8, 64'h5);
    erd(4'd8, 64'hA, "R7 host plain write first");
    cyc(1, 1, 4'd11, 64'h1, 1, 1, 4'd12, 64'h8);
    hrd(4'd11, 64'h9, "R7 plain plus set");

    @(negedge clk);
    @(negedge clk);
    chk(64'(hq.size() + eq.size()), 0, "R2 all reads returned");
    finish_run();
  end
endmodule